// File: doc/BRIEF.md
# Thermal Spare Core Manager

This block manages a small array of processor cores. Each core holds one of three roles: working, warm reserve, or dark reserve. A warm reserve has power but no clock, so it leaks and keeps its state, and it can take over at once. A dark reserve has no power and gives off no heat, so bringing it up takes longer. A per-core temperature reading is compared against a software-chosen evacuation threshold. That threshold sits between the steady-state and throttling temperatures, and is set from how long a core needs to empty.

When a working core reaches the threshold, the manager first marks that core as closed to new work for the scheduler. It then wakes a reserve, preferring a warm one. A warm reserve has its clock enabled in the same step. A dark reserve has its power switched on first, then its clock after a programmable settling delay. The manager then asks the scheduler to move the threads across and waits for an acknowledge. The emptied core keeps power with its clock stopped, and rejoins the warm pool only after it has cooled by a hysteresis margin. If no reserve exists, a throttle request is raised in place of a migration request.

Only one evacuation runs at a time. Further overheated cores wait until the current one has finished.

Top module: `scm_top`

## Requirements
- R1: After reset, cores in `HOT_MASK` have `pwr_en`=1 and `clk_en`=0, cores in `COLD_MASK` have both at 0, and all other cores have both at 1. `no_new_task` is 1 exactly for the non-working cores. `mig_req` and `throttle_req` are 0.
- R2: While idle, a working core whose temperature is at or above `mig_thr` is chosen for evacuation. When several qualify, the lowest index is chosen. Its `no_new_task` bit rises on the next cycle.
- R3: If a warm reserve exists, the lowest-index one is taken. Its `clk_en` rises in the same cycle as the source's `no_new_task` and `mig_req`. `mig_src` and `mig_dst` give the core indices.
- R4: If no warm reserve exists, the lowest-index dark reserve is taken. Its `pwr_en` rises first, and its `clk_en` rises exactly `pg_delay`+1 cycles later, together with `mig_req`.
- R5: `mig_req` stays high, with `mig_src` and `mig_dst` unchanged, until a cycle with `mig_ack` high. It is low on the following cycle.
- R6: On the cycle after the acknowledge, the source core has `clk_en`=0, `pwr_en`=1 and `no_new_task`=1. It becomes an eligible warm reserve only once `temp + hyst < mig_thr`.
- R7: When no reserve exists, `throttle_req` is raised instead of `mig_req`. The request ends either when the source cools (`temp + hyst < mig_thr`), which releases its `no_new_task` bit, or when a reserve appears, which leads to a migration.
- R8: A core's clock is never enabled without its power. A core whose power turns on does not get its clock in that same cycle.
- R9: At most one working core is under evacuation at any time. Other hot cores keep `no_new_task`=0 until the current evacuation ends.
- R10: The cool-down test does not wrap. If `hyst` is at least `mig_thr`, a drained core never becomes a reserve again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temps | input | N_CORES*TEMP_W | Per-core temperatures; core i uses bits [i*TEMP_W +: TEMP_W] |
| mig_thr | input | TEMP_W | Evacuation threshold |
| hyst | input | TEMP_W | Cool-down margin below the threshold |
| pg_delay | input | DLY_W | Power-settle delay for dark reserves, in cycles |
| mig_ack | input | 1 | Scheduler acknowledge: threads have moved |
| pwr_en | output | N_CORES | Per-core power enable |
| clk_en | output | N_CORES | Per-core clock enable |
| no_new_task | output | N_CORES | Per-core mask: do not schedule new work |
| mig_req | output | 1 | Request to migrate threads from `mig_src` to `mig_dst` |
| mig_src | output | IDX_W | Index of the overheated core |
| mig_dst | output | IDX_W | Index of the activated reserve |
| throttle_req | output | 1 | Overheated core with no reserve available |

## Verification
The checker monitors the following on every cycle:
- power-before-clock ordering on every core;
- the stability of the migration request until its acknowledge;
- the source and destination states while a request is pending and on the cycle after the acknowledge;
- mutual exclusion of the migration and throttle requests;
- the single-evacuation limit.

Some behaviours need scenarios driven by the bench: the selection order across reserve classes, the exact dark-reserve settling count, the two ways out of throttling, and the saturating hysteresis that keeps a drained core out of the pool. The bench walks through these while a behavioural reference model is compared with every output on every clock.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int CMP_W = 16;

  typedef enum logic [2:0] {
    ROLE_ACTIVE,
    ROLE_HOT,
    ROLE_COLD,
    ROLE_WAKE,
    ROLE_DRAIN
  } role_e;

  typedef enum logic [1:0] {
    FSM_IDLE,
    FSM_WAKE,
    FSM_MIG,
    FSM_THR
  } fsm_e;

  // Overheat: reading at or above the threshold.
  function automatic logic over_thr(input logic [CMP_W-1:0] t,
                                    input logic [CMP_W-1:0] thr);
    return t >= thr;
  endfunction

  // Cooled: reading plus margin strictly below threshold, computed wide so it cannot wrap.
  function automatic logic cooled(input logic [CMP_W-1:0] t,
                                  input logic [CMP_W-1:0] thr,
                                  input logic [CMP_W-1:0] hy);
    logic [CMP_W:0] sum;
    sum = {1'b0, t} + {1'b0, hy};
    return sum < {1'b0, thr};
  endfunction
endpackage

// File: rtl/scm_temp_cmp.sv
module scm_temp_cmp #(
  parameter int N_CORES = 4,
  parameter int TEMP_W  = 8
) (
  input  logic [N_CORES*TEMP_W-1:0] temps,
  input  logic [TEMP_W-1:0]         mig_thr,
  input  logic [TEMP_W-1:0]         hyst,
  output logic [N_CORES-1:0]        over,
  output logic [N_CORES-1:0]        cool
);
  import scm_pkg::*;
  localparam int PAD = CMP_W - TEMP_W;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    logic [CMP_W-1:0] t_ext;
    assign t_ext   = {{PAD{1'b0}}, temps[i*TEMP_W +: TEMP_W]};
    assign over[i] = over_thr(t_ext, {{PAD{1'b0}}, mig_thr});
    assign cool[i] = cooled(t_ext, {{PAD{1'b0}}, mig_thr}, {{PAD{1'b0}}, hyst});
  end
endmodule

// File: rtl/scm_first_pick.sv
module scm_first_pick #(
  parameter int N_CORES = 4,
  parameter int IDX_W   = 2
) (
  input  logic [N_CORES-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/scm_role_bank.sv
module scm_role_bank #(
  parameter int               N_CORES   = 4,
  parameter logic [N_CORES-1:0] HOT_MASK  = '0,
  parameter logic [N_CORES-1:0] COLD_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] set_active,
  input  logic [N_CORES-1:0] set_wake,
  input  logic [N_CORES-1:0] set_drain,
  input  logic [N_CORES-1:0] cool,
  output logic [N_CORES-1:0] is_active,
  output logic [N_CORES-1:0] is_hot,
  output logic [N_CORES-1:0] is_cold,
  output logic [N_CORES-1:0] pwr_en,
  output logic [N_CORES-1:0] clk_en
);
  import scm_pkg::*;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    localparam role_e INIT = HOT_MASK[i]  ? ROLE_HOT  :
                             COLD_MASK[i] ? ROLE_COLD : ROLE_ACTIVE;
    role_e role_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               role_q <= INIT;
      else if (set_active[i])                   role_q <= ROLE_ACTIVE;
      else if (set_wake[i])                     role_q <= ROLE_WAKE;
      else if (set_drain[i])                    role_q <= ROLE_DRAIN;
      else if (role_q == ROLE_DRAIN && cool[i]) role_q <= ROLE_HOT;
    end

    assign is_active[i] = (role_q == ROLE_ACTIVE);
    assign is_hot[i]    = (role_q == ROLE_HOT);
    assign is_cold[i]   = (role_q == ROLE_COLD);
    assign clk_en[i]    = (role_q == ROLE_ACTIVE);
    assign pwr_en[i]    = (role_q != ROLE_COLD);
  end
endmodule

// File: rtl/scm_top.sv
module scm_top #(
  parameter int               N_CORES   = 4,
  parameter int               TEMP_W    = 8,
  parameter int               DLY_W     = 8,
  parameter logic [N_CORES-1:0] HOT_MASK  = 4'b1000,
  parameter logic [N_CORES-1:0] COLD_MASK = 4'b0100,
  localparam int              IDX_W     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES*TEMP_W-1:0] temps,
  input  logic [TEMP_W-1:0]         mig_thr,
  input  logic [TEMP_W-1:0]         hyst,
  input  logic [DLY_W-1:0]          pg_delay,
  input  logic                      mig_ack,
  output logic [N_CORES-1:0]        pwr_en,
  output logic [N_CORES-1:0]        clk_en,
  output logic [N_CORES-1:0]        no_new_task,
  output logic                      mig_req,
  output logic [IDX_W-1:0]          mig_src,
  output logic [IDX_W-1:0]          mig_dst,
  output logic                      throttle_req
);
  import scm_pkg::*;

  function automatic logic [N_CORES-1:0] onehot(input logic [IDX_W-1:0] i);
    logic [N_CORES-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  logic [N_CORES-1:0] over, cool;
  logic [N_CORES-1:0] is_active, is_hot, is_cold;
  logic [N_CORES-1:0] set_active, set_wake, set_drain;
  logic               trig_any, hot_any, cold_any;
  logic [IDX_W-1:0]   trig_idx, hot_idx, cold_idx;

  fsm_e               st_q, st_d;
  logic [IDX_W-1:0]   src_q, src_d, dst_q, dst_d;
  logic [DLY_W-1:0]   cnt_q, cnt_d;
  logic [N_CORES-1:0] evac_q, evac_d;
  logic               take_spare;

  // named events for the checker
  logic ev_trigger, ev_hot_take, ev_cold_take, ev_release;

  scm_temp_cmp #(.N_CORES(N_CORES), .TEMP_W(TEMP_W)) u_cmp (
    .temps(temps), .mig_thr(mig_thr), .hyst(hyst), .over(over), .cool(cool)
  );

  scm_first_pick #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_pick_trig (
    .req(is_active & over), .found(trig_any), .idx(trig_idx)
  );
  scm_first_pick #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_pick_hot (
    .req(is_hot), .found(hot_any), .idx(hot_idx)
  );
  scm_first_pick #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_pick_cold (
    .req(is_cold), .found(cold_any), .idx(cold_idx)
  );

  scm_role_bank #(.N_CORES(N_CORES), .HOT_MASK(HOT_MASK), .COLD_MASK(COLD_MASK)) u_roles (
    .clk(clk), .rst_n(rst_n),
    .set_active(set_active), .set_wake(set_wake), .set_drain(set_drain), .cool(cool),
    .is_active(is_active), .is_hot(is_hot), .is_cold(is_cold),
    .pwr_en(pwr_en), .clk_en(clk_en)
  );

  always_comb begin
    st_d       = st_q;
    src_d      = src_q;
    dst_d      = dst_q;
    cnt_d      = cnt_q;
    evac_d     = evac_q;
    set_active = '0;
    set_wake   = '0;
    set_drain  = '0;
    take_spare = 1'b0;
    ev_trigger = 1'b0;
    ev_release = 1'b0;
    unique case (st_q)
      FSM_IDLE: if (trig_any) begin
        src_d      = trig_idx;
        evac_d     = onehot(trig_idx);
        take_spare = 1'b1;
        ev_trigger = 1'b1;
      end
      FSM_WAKE: if (cnt_q == '0) begin
        set_active = onehot(dst_q);
        st_d       = FSM_MIG;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      FSM_MIG: if (mig_ack) begin
        set_drain = onehot(src_q);
        evac_d    = '0;
        st_d      = FSM_IDLE;
      end
      FSM_THR: if (cool[src_q]) begin
        evac_d     = '0;
        st_d       = FSM_IDLE;
        ev_release = 1'b1;
      end else begin
        take_spare = 1'b1;
      end
      default: st_d = FSM_IDLE;
    endcase
    ev_hot_take  = take_spare && hot_any;
    ev_cold_take = take_spare && !hot_any && cold_any;
    if (ev_hot_take) begin
      set_active = onehot(hot_idx);
      dst_d      = hot_idx;
      st_d       = FSM_MIG;
    end else if (ev_cold_take) begin
      set_wake = onehot(cold_idx);
      dst_d    = cold_idx;
      cnt_d    = pg_delay;
      st_d     = FSM_WAKE;
    end else if (take_spare) begin
      st_d = FSM_THR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FSM_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      evac_q <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      evac_q <= evac_d;
    end
  end

  assign no_new_task  = evac_q | ~is_active;
  assign mig_req      = (st_q == FSM_MIG);
  assign throttle_req = (st_q == FSM_THR);
  assign mig_src      = src_q;
  assign mig_dst      = dst_q;
endmodule

// File: rtl/scm_checker.sv
module scm_checker #(
  parameter int N_CORES = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CORES-1:0] pwr_en,
  input logic [N_CORES-1:0] clk_en,
  input logic [N_CORES-1:0] no_new_task,
  input logic               mig_req,
  input logic               mig_ack,
  input logic [IDX_W-1:0]   mig_src,
  input logic [IDX_W-1:0]   mig_dst,
  input logic               throttle_req,
  input logic               ev_trigger,
  input logic               ev_cold_take
);
  // R8
  clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en & ~pwr_en) == '0);

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    // R8
    pwr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en[i]) |-> !clk_en[i]);
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req && !mig_ack |=> mig_req && $stable(mig_src) && $stable(mig_dst));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req && mig_ack |=> !mig_req);

  // R3
  req_endpoints_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req |-> clk_en[mig_dst] && no_new_task[mig_src] && !no_new_task[mig_dst]);

  // R6
  src_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mig_req && mig_ack |=> !clk_en[mig_src] && pwr_en[mig_src] && no_new_task[mig_src]);

  // R7
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mig_req && throttle_req));

  // R9
  single_evac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(no_new_task & clk_en) <= 1);

  // R2
  trigger_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trigger |=> no_new_task[mig_src]);

  // R4
  cold_power_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cold_take |=> pwr_en[mig_dst] && !clk_en[mig_dst] && !mig_req);
endmodule

bind scm_top scm_checker #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .clk_en(clk_en),
  .no_new_task(no_new_task), .mig_req(mig_req), .mig_ack(mig_ack),
  .mig_src(mig_src), .mig_dst(mig_dst), .throttle_req(throttle_req),
  .ev_trigger(ev_trigger), .ev_cold_take(ev_cold_take)
);

// File: tb/scm_top_test.sv
module scm_top_test;
  localparam int N = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*TW-1:0] temps;
  logic [TW-1:0] mig_thr = 8'd80;
  logic [TW-1:0] hyst = 8'd6;
  logic [7:0] pg_delay = 8'd3;
  logic mig_ack = 1'b0;
  logic [N-1:0] pwr_en, clk_en, no_new_task;
  logic mig_req, throttle_req;
  logic [1:0] mig_src, mig_dst;

  int tv[N] = '{50, 50, 50, 50};
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always_comb for (int i = 0; i < N; i++) temps[i*TW +: TW] = tv[i][TW-1:0];

  always #4 clk = ~clk;

  scm_top uut (
    .clk(clk), .rst_n(rst_n), .temps(temps), .mig_thr(mig_thr), .hyst(hyst),
    .pg_delay(pg_delay), .mig_ack(mig_ack), .pwr_en(pwr_en), .clk_en(clk_en),
    .no_new_task(no_new_task), .mig_req(mig_req), .mig_src(mig_src),
    .mig_dst(mig_dst), .throttle_req(throttle_req)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // reference model: role 0 working, 1 warm reserve, 2 dark, 3 powering, 4 cooling
  int m_role[N];
  int m_st, m_src, m_dst, m_cnt;
  bit m_evac[N];

  function automatic bit m_cool(int i);
    return (tv[i] + int'(hyst)) < int'(mig_thr);
  endfunction

  task automatic model_reset();
    m_role = '{0, 0, 2, 1};
    m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0;
    m_evac = '{0, 0, 0, 0};
  endtask

  task automatic model_step();
    int nr[N];
    int hs = -1, cs = -1, tg = -1, ost = m_st;
    bit take = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_role[i] == 1) hs = i;
      if (m_role[i] == 2) cs = i;
      if (m_role[i] == 0 && tv[i] >= int'(mig_thr)) tg = i;
    end
    for (int i = 0; i < N; i++) nr[i] = (m_role[i] == 4 && m_cool(i)) ? 1 : m_role[i];
    case (ost)
      0: if (tg >= 0) begin
        m_src = tg;
        for (int i = 0; i < N; i++) m_evac[i] = (i == tg);
        take = 1;
      end
      1: if (m_cnt == 0) begin nr[m_dst] = 0; m_st = 2; end
         else m_cnt--;
      2: if (mig_ack) begin
        nr[m_src] = 4;
        for (int i = 0; i < N; i++) m_evac[i] = 0;
        m_st = 0;
      end
      default: if (m_cool(m_src)) begin
        for (int i = 0; i < N; i++) m_evac[i] = 0;
        m_st = 0;
      end else take = 1;
    endcase
    if (take) begin
      if (hs >= 0) begin nr[hs] = 0; m_dst = hs; m_st = 2; end
      else if (cs >= 0) begin nr[cs] = 3; m_dst = cs; m_cnt = int'(pg_delay); m_st = 1; end
      else m_st = 3;
    end
    m_role = nr;
  endtask

  task automatic compare();
    logic [N-1:0] ep, ec, en;
    for (int i = 0; i < N; i++) begin
      ep[i] = (m_role[i] != 2);
      ec[i] = (m_role[i] == 0);
      en[i] = (m_role[i] != 0) || m_evac[i];
    end
    check(pwr_en == ep && clk_en == ec, "R8 R1 power/clock enables",
          int'({pwr_en, clk_en}), int'({ep, ec}));
    check(no_new_task == en, "R2 R9 no_new_task mask", int'(no_new_task), int'(en));
    check(mig_req == (m_st == 2), "R5 mig_req", int'(mig_req), int'(m_st == 2));
    check(throttle_req == (m_st == 3), "R7 throttle_req", int'(throttle_req), int'(m_st == 3));
    if (m_st == 2)
      check(int'(mig_src) == m_src && int'(mig_dst) == m_dst, "R3 src/dst",
            int'(mig_src) * 10 + int'(mig_dst), m_src * 10 + m_dst);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else model_step();
    #1;
    if (!done) compare();
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_req(input string tag);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (mig_req) return;
    end
    check(0, {tag, " timeout waiting for mig_req"}, 0, 1);
  endtask

  task automatic pulse_ack();
    @(negedge clk) mig_ack = 1'b1;
    @(negedge clk) mig_ack = 1'b0;
  endtask

  initial begin
    #800000;
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int p, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwr_en == 4'b1011, "R1 reset pwr_en", int'(pwr_en), 11);
    check(clk_en == 4'b0011, "R1 reset clk_en", int'(clk_en), 3);
    check(no_new_task == 4'b1100, "R1 reset no_new_task", int'(no_new_task), 12);
    check(!mig_req && !throttle_req, "R1 reset requests", int'({mig_req, throttle_req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R9: two hot working cores, lowest index goes first to warm reserve 3
    tv[0] = 85; tv[1] = 85;
    wait_req("R3");
    check(mig_src == 2'd0 && mig_dst == 2'd3, "R3 R2 hot reserve pick",
          int'(mig_src) * 10 + int'(mig_dst), 3);
    check(clk_en[3] && no_new_task[0], "R3 dst clocked, src marked", int'({clk_en[3], no_new_task[0]}), 3);
    check(!no_new_task[1], "R9 second hot core waits", int'(no_new_task[1]), 0);
    repeat (4) @(negedge clk);
    check(mig_req && mig_src == 2'd0 && mig_dst == 2'd3, "R5 request held", int'(mig_req), 1);
    pulse_ack();
    check(!mig_req, "R5 request dropped after ack", int'(mig_req), 0);
    check(!clk_en[0] && pwr_en[0] && no_new_task[0], "R6 source parked",
          int'({clk_en[0], pwr_en[0], no_new_task[0]}), 3);

    // R4: core 1 now goes to dark reserve 2
    p = -1; c = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwr_en[2] && p < 0) p = cyc;
      if (clk_en[2] && c < 0) c = cyc;
      if (mig_req) break;
    end
    check(c - p == int'(pg_delay) + 1, "R4 power-to-clock delay", c - p, int'(pg_delay) + 1);
    check(mig_src == 2'd1 && mig_dst == 2'd2, "R4 dark reserve pick",
          int'(mig_src) * 10 + int'(mig_dst), 12);
    pulse_ack();

    // R7: no reserve, then a cooled drained core becomes one
    tv[2] = 90;
    repeat (3) @(negedge clk);
    check(throttle_req && !mig_req, "R7 throttle without reserve", int'({throttle_req, mig_req}), 2);
    tv[0] = 70;
    wait_req("R7");
    check(mig_src == 2'd2 && mig_dst == 2'd0, "R6 R7 cooled core reused",
          int'(mig_src) * 10 + int'(mig_dst), 20);
    pulse_ack();

    // R7: throttle released by cooling
    tv[3] = 95;
    repeat (3) @(negedge clk);
    check(throttle_req, "R7 throttle on core 3", int'(throttle_req), 1);
    tv[3] = 70;
    repeat (2) @(negedge clk);
    check(!throttle_req && !no_new_task[3], "R7 release on cooling",
          int'({throttle_req, no_new_task[3]}), 0);

    // R10: margin above threshold keeps drained core out
    hyst = 8'd200; tv[1] = 0;
    repeat (5) @(negedge clk);
    check(!clk_en[1] && pwr_en[1], "R10 drained core stays parked", int'({clk_en[1], pwr_en[1]}), 1);
    tv[3] = 95;
    repeat (3) @(negedge clk);
    check(throttle_req, "R10 no reserve while margin saturates", int'(throttle_req), 1);
    hyst = 8'd6;
    wait_req("R10");
    check(mig_src == 2'd3 && mig_dst == 2'd1, "R10 reuse once margin sane",
          int'(mig_src) * 10 + int'(mig_dst), 31);
    pulse_ack();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule